// File: doc/BRIEF.md
# SMBus Register-File Slave

This block is a two-wire serial slave that exposes a small file of 8-bit control registers to a system management host. It watches the clock and data lines as plain inputs, drives the data line only by pulling it low, and serves four transfers: single-register write, single-register read, multi-register (block) write and block read. The command byte that follows the device address picks the transfer type. With its top bit set, the low seven bits name one register. With the top bit clear, the transfer starts at register 0 and walks upward.

Each register bit has its own power-up value and one of three behaviours: ordinary read/write, read-only, or cleared by writing a one. The read-only bits of the strap register capture an 8-bit strap input while reset is held. Every accepted write that lands inside the register file also appears for one cycle on a strobe bus with its offset and data. Neighbouring logic can use this to react to updates of particular registers, such as divider settings. The whole register image is always visible on a flat output bus.

Top module: `smb_regslave`

## Requirements
- R1: Only the 7-bit device address 69h (address byte D2h for write, D3h for read) is acknowledged. Any other address byte is not acknowledged, and every byte after it is ignored and not acknowledged until the next start condition.
- R2: A command byte with bit 7 = 1 selects single-register mode with offset = bits 6:0. In a single-register write exactly one data byte is acknowledged and stored. A further data byte is not acknowledged and changes nothing.
- R3: A single-register read (command, repeated start, D3h) returns the register at the selected offset, most significant bit first.
- R4: A command byte with bit 7 = 0 selects block mode starting at offset 0. In a block write the first byte after the command is a count. Up to that many data bytes are acknowledged and stored at offsets 0, 1, 2, …, and bytes beyond the count are not acknowledged and not stored.
- R5: A block read first returns the count 18 (12h), then registers 0, 1, 2, … in order, and it stops after the byte the host does not acknowledge.
- R6: After reset the register image holds the power-up values: offset 1 = 0Fh, offset 2 = FFh, offset 3 = 3Fh, offset 5 = F5h, offsets 6 and 7 = FFh, offset 8 = 05h, offset 15 = strap bits 7:3 merged with 03h in bits 2:0, and all other offsets = 00h. The data line is released.
- R7: Writes leave read-only bits unchanged: all of offset 8, and bits 7:3 of offset 15.
- R8: Bit 2 of offset 9 is set by a one-cycle pulse on its bit of the hardware-set input (bit index 74). Writing 1 to that bit clears it, and writing 0 leaves it set. A hardware set in the same cycle as a clearing write wins.
- R9: Every stored data byte produces exactly one single-cycle strobe that carries its offset and the data byte as written.
- R10: Offsets 18 and above are acknowledged on write but discarded without a strobe, and they read as 00h (including the 19th data byte of a block read).
- R11: The data line changes only while the clock line is low, except where a start or stop forces a release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 = pull the data line low |
| strap_i | input | 8 | Strap levels captured into read-only bits of offset 15 during reset |
| hw_set_i | input | NUM_REGS*8 | Per-bit hardware set pulses for write-one-to-clear bits |
| cfg_o | output | NUM_REGS*8 | Register image, offset n at bits 8n+7:8n |
| wr_stb_o | output | 1 | One-cycle pulse per stored byte |
| wr_off_o | output | 8 | Offset of the stored byte |
| wr_dat_o | output | 8 | Data byte as written |

## Verification
The protocol engine is tried with single-register writes and reads at several offsets, block writes whose data run past the stated count, and block reads that run to the end of the file and one byte past it. These tell the count-limited acknowledge apart from the single-byte limit, and the in-range pointer apart from the out-of-range one. A foreign address followed by extra bytes separates a correct ignore from a partial decode. Writes of patterns that hit read-only bits, and of ones and zeros to the clear-on-one bit around a hardware set pulse, tell the three bit behaviours apart. A scoreboard pairs every expected strobe with the one the block emits.

// File: rtl/smb_regslave_pkg.sv
package smb_regslave_pkg;

  localparam int REG_BYTES = 18;
  localparam int OFF_W     = 8;

  // Power-up image, offset 17 in the top byte down to offset 0
  localparam logic [REG_BYTES*8-1:0] DEF_IMAGE = {
    8'h00, 8'h00, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
    8'h05, 8'hFF, 8'hFF, 8'hF5, 8'h00, 8'h3F, 8'hFF, 8'h0F, 8'h00
  };

  // Read-only bits: id byte at offset 8, strap field at offset 15
  localparam logic [REG_BYTES*8-1:0] RO_IMAGE =
    {16'h0000, 8'hF8, {6{8'h00}}, 8'hFF, {8{8'h00}}};

  // Clear-on-one bits: status flag at offset 9 bit 2
  localparam logic [REG_BYTES*8-1:0] W1C_IMAGE =
    {{8{8'h00}}, 8'h04, {9{8'h00}}};

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_CMD, PH_CNT, PH_WDATA, PH_RDATA, PH_DROP
  } smb_phase_t;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);

  logic [STAGES-1:0] scl_sh, sda_sh;
  logic              scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s    = scl_sh[STAGES-1];
  assign sda_s    = sda_sh[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs #(
  parameter int NUM_REGS  = 18,
  parameter int OFF_W     = 8,
  parameter int STRAP_IDX = 15,
  parameter logic [NUM_REGS*8-1:0] DEF_IMAGE = '0,
  parameter logic [NUM_REGS*8-1:0] RO_MASK   = '0,
  parameter logic [NUM_REGS*8-1:0] W1C_MASK  = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [7:0]            strap_i,
  input  logic [NUM_REGS*8-1:0] set_i,
  input  logic                  wr_en,
  input  logic [OFF_W-1:0]      wr_off,
  input  logic [7:0]            wr_dat,
  input  logic [OFF_W-1:0]      rd_off,
  output logic [7:0]            rd_byte,
  output logic [NUM_REGS*8-1:0] cfg_o
);

  logic armed;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_byte
    localparam logic [7:0] DEF = DEF_IMAGE[8*i +: 8];
    localparam logic [7:0] RO  = RO_MASK[8*i +: 8];
    localparam logic [7:0] WC  = W1C_MASK[8*i +: 8] & ~RO_MASK[8*i +: 8];
    localparam logic [7:0] RW  = ~(RO | WC);
    localparam logic [7:0] INIT_FIXED = DEF & ~RO;

    logic [7:0] r, r_nxt;
    logic       hit;

    assign hit = wr_en && (wr_off == OFF_W'(i));

    always_comb begin
      r_nxt = r;
      if (hit) begin
        r_nxt = (r & ~RW) | (wr_dat & RW);
        r_nxt = r_nxt & ~(wr_dat & WC);
      end
      r_nxt = r_nxt | (set_i[8*i +: 8] & WC);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        if (i == STRAP_IDX) r <= INIT_FIXED | (strap_i & RO);
        else                r <= DEF;
      end else begin
        r <= r_nxt;
      end
    end

    assign cfg_o[8*i +: 8] = r;
  end

  always_comb begin
    rd_byte = 8'h00;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (rd_off == OFF_W'(k)) rd_byte = cfg_o[8*k +: 8];
    end
  end

  // R7
  ro_hold_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> ((cfg_o & RO_MASK) == ($past(cfg_o) & RO_MASK)));

  // R8
  w1c_set_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> ((cfg_o & $past(set_i) & W1C_MASK) == ($past(set_i) & W1C_MASK)));

endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
  import smb_regslave_pkg::*;
#(
  parameter int         NUM_REGS = 18,
  parameter int         OFF_W    = 8,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_p,
  input  logic             stop_p,
  input  logic [7:0]       rd_byte,
  output logic [OFF_W-1:0] rd_off,
  output logic             sda_drv,
  output logic             wr_stb,
  output logic [OFF_W-1:0] wr_off,
  output logic [7:0]       wr_dat
);

  localparam logic [OFF_W-1:0] LIMIT   = OFF_W'(NUM_REGS);
  localparam logic [7:0]       CNT_VAL = 8'(NUM_REGS);
  localparam logic [OFF_W-1:0] PTR_MAX = '1;

  smb_phase_t       phase;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg, tx, left;
  logic [OFF_W-1:0] ptr;
  logic             in_ack, rw, byte_mode, mnack, armed;

  function automatic logic [OFF_W-1:0] bump(input logic [OFF_W-1:0] p);
    return (p == PTR_MAX) ? p : p + OFF_W'(1);
  endfunction

  assign rd_off = ptr;

  always_ff @(posedge clk) begin
    wr_stb <= 1'b0;
    if (rst) begin
      phase     <= PH_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      tx        <= '0;
      left      <= '0;
      ptr       <= '0;
      in_ack    <= 1'b0;
      rw        <= 1'b0;
      byte_mode <= 1'b1;
      mnack     <= 1'b0;
      sda_drv   <= 1'b0;
      wr_off    <= '0;
      wr_dat    <= '0;
      armed     <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (start_p) begin
        phase   <= PH_ADDR;
        bitcnt  <= '0;
        in_ack  <= 1'b0;
        sda_drv <= 1'b0;
      end else if (stop_p) begin
        phase   <= PH_IDLE;
        in_ack  <= 1'b0;
        sda_drv <= 1'b0;
      end else if (phase == PH_RDATA) begin
        if (scl_rise) begin
          if (in_ack) mnack  <= sda_s;
          else        bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall) begin
          if (in_ack) begin
            in_ack <= 1'b0;
            bitcnt <= '0;
            if (mnack) begin
              phase   <= PH_DROP;
              sda_drv <= 1'b0;
            end else begin
              tx      <= rd_byte;
              sda_drv <= ~rd_byte[7];
              ptr     <= bump(ptr);
            end
          end else if (bitcnt == 4'd8) begin
            sda_drv <= 1'b0;
            in_ack  <= 1'b1;
          end else begin
            tx      <= {tx[6:0], 1'b0};
            sda_drv <= ~tx[6];
          end
        end
      end else if (phase != PH_IDLE && phase != PH_DROP) begin
        if (scl_rise && !in_ack) begin
          shreg  <= {shreg[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall && in_ack) begin
          in_ack  <= 1'b0;
          bitcnt  <= '0;
          sda_drv <= 1'b0;
          unique case (phase)
            PH_ADDR: begin
              if (rw) begin
                phase <= PH_RDATA;
                mnack <= 1'b0;
                if (byte_mode) begin
                  tx      <= rd_byte;
                  sda_drv <= ~rd_byte[7];
                  ptr     <= bump(ptr);
                end else begin
                  tx      <= CNT_VAL;
                  sda_drv <= ~CNT_VAL[7];
                end
              end else begin
                phase <= PH_CMD;
              end
            end
            PH_CMD:  phase <= byte_mode ? PH_WDATA : PH_CNT;
            default: phase <= PH_WDATA;
          endcase
        end else if (scl_fall && bitcnt == 4'd8) begin
          unique case (phase)
            PH_ADDR: begin
              if (shreg[7:1] == DEV_ADDR) begin
                sda_drv <= 1'b1;
                in_ack  <= 1'b1;
                rw      <= shreg[0];
              end else begin
                phase <= PH_DROP;
              end
            end
            PH_CMD: begin
              sda_drv   <= 1'b1;
              in_ack    <= 1'b1;
              byte_mode <= shreg[7];
              ptr       <= shreg[7] ? OFF_W'(shreg[6:0]) : '0;
              left      <= 8'd1;
            end
            PH_CNT: begin
              sda_drv <= 1'b1;
              in_ack  <= 1'b1;
              left    <= shreg;
            end
            default: begin
              if (left != 8'd0) begin
                sda_drv <= 1'b1;
                in_ack  <= 1'b1;
                left    <= left - 8'd1;
                ptr     <= bump(ptr);
                if (ptr < LIMIT) begin
                  wr_stb <= 1'b1;
                  wr_off <= ptr;
                  wr_dat <= shreg;
                end
              end else begin
                phase <= PH_DROP;
              end
            end
          endcase
        end
      end
    end
  end

  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  // R10
  strobe_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (wr_off < LIMIT));

  // R11
  sda_low_scl_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !$stable(sda_drv) && !$past(start_p || stop_p)) |-> !$past(scl_s));

  // R1
  drop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DROP && !start_p && !stop_p) |=> !sda_drv);

endmodule

// File: rtl/smb_regslave.sv
module smb_regslave
  import smb_regslave_pkg::*;
#(
  parameter int         NUM_REGS    = REG_BYTES,
  parameter int         SYNC_STAGES = 2,
  parameter int         STRAP_IDX   = 15,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter logic [NUM_REGS*8-1:0] DEF_VAL  = DEF_IMAGE,
  parameter logic [NUM_REGS*8-1:0] RO_BITS  = RO_IMAGE,
  parameter logic [NUM_REGS*8-1:0] W1C_BITS = W1C_IMAGE
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  input  logic [7:0]            strap_i,
  input  logic [NUM_REGS*8-1:0] hw_set_i,
  output logic [NUM_REGS*8-1:0] cfg_o,
  output logic                  wr_stb_o,
  output logic [OFF_W-1:0]      wr_off_o,
  output logic [7:0]            wr_dat_o
);

  logic             scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic [OFF_W-1:0] rd_off;
  logic [7:0]       rd_byte;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  smb_proto_fsm #(.NUM_REGS(NUM_REGS), .OFF_W(OFF_W), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p),
    .rd_byte(rd_byte), .rd_off(rd_off), .sda_drv(sda_oe),
    .wr_stb(wr_stb_o), .wr_off(wr_off_o), .wr_dat(wr_dat_o)
  );

  smb_cfg_regs #(
    .NUM_REGS(NUM_REGS), .OFF_W(OFF_W), .STRAP_IDX(STRAP_IDX),
    .DEF_IMAGE(DEF_VAL), .RO_MASK(RO_BITS), .W1C_MASK(W1C_BITS)
  ) u_regs (
    .clk(clk), .rst(rst), .strap_i(strap_i), .set_i(hw_set_i),
    .wr_en(wr_stb_o), .wr_off(wr_off_o), .wr_dat(wr_dat_o),
    .rd_off(rd_off), .rd_byte(rd_byte), .cfg_o(cfg_o)
  );

endmodule

// File: tb/sim_smb_regslave.sv
module sim_smb_regslave;

  localparam int NR = 18;
  localparam int Q  = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, sda_line;
  logic [7:0] strap = 8'hA8;
  logic [NR*8-1:0] hw_set = '0;
  logic [NR*8-1:0] cfg;
  logic wr_stb;
  logic [7:0] wr_off, wr_dat;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] mdl [NR];
  logic [15:0] exp_q [$];

  always #2.5 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  smb_regslave u0 (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(strap), .hw_set_i(hw_set), .cfg_o(cfg),
    .wr_stb_o(wr_stb), .wr_off_o(wr_off), .wr_dat_o(wr_dat)
  );

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Scoreboard monitor (R9): every strobe must match the oldest expected item
  always @(negedge clk) begin
    if (!rst && wr_stb) begin
      if (exp_q.size() == 0) begin
        chk("R9 unexpected strobe offset", wr_off, 8'hXX);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk("R9 strobe offset", wr_off, e[15:8]);
        chk("R9 strobe data", wr_dat, e[7:0]);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(2*Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(2*Q);
    m_sda = 1'b1; tick(2*Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; tick(Q);
    m_scl = 1'b1; tick(2*Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output logic v);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    v = sda_line; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(a);
    ack = ~a;
  endtask

  task automatic rd_byte(output logic [7:0] b, input logic mack);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(v);
      b[i] = v;
    end
    send_bit(~mack);
  endtask

  function automatic logic [7:0] apply_wr(input int off, input logic [7:0] old, input logic [7:0] d);
    if (off == 8)  return old;
    if (off == 15) return {old[7:3], d[2:0]};
    if (off == 9)  return {d[7:3], old[2] & ~d[2], d[1:0]};
    return d;
  endfunction

  task automatic single_write(input int off, input logic [7:0] d, input string r);
    logic a;
    if (off < NR) begin
      exp_q.push_back({8'(off), d});
      mdl[off] = apply_wr(off, mdl[off], d);
    end
    bus_start;
    wr_byte(8'hD2, a); chk({r, " addr ack"}, {7'd0, a}, 8'd1);
    wr_byte({1'b1, 7'(off)}, a); chk({r, " cmd ack"}, {7'd0, a}, 8'd1);
    wr_byte(d, a); chk({r, " data ack"}, {7'd0, a}, 8'd1);
    bus_stop;
  endtask

  task automatic single_read(input int off, output logic [7:0] d);
    logic a;
    bus_start;
    wr_byte(8'hD2, a);
    wr_byte({1'b1, 7'(off)}, a);
    bus_start;
    wr_byte(8'hD3, a); chk("R3 read addr ack", {7'd0, a}, 8'd1);
    rd_byte(d, 1'b0);
    bus_stop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic a;
    mdl = '{8'h00, 8'h0F, 8'hFF, 8'h3F, 8'h00, 8'hF5, 8'hFF, 8'hFF, 8'h05,
            8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hAB, 8'h00, 8'h00};
    tick(5);
    rst = 1'b0;
    tick(5);

    // R6: reset image and released line
    chk("R6 sda released", {7'd0, sda_oe}, 8'd0);
    for (int i = 0; i < NR; i++) chk("R6 reset value", cfg[8*i +: 8], mdl[i]);

    // R3: single read at offset 2 and offset 5
    single_read(2, d); chk("R3 read off2", d, 8'hFF);
    single_read(5, d); chk("R3 read off5", d, 8'hF5);

    // R2 R9: single write then read back
    single_write(0, 8'h5A, "R2");
    single_read(0, d); chk("R2 readback off0", d, 8'h5A);
    chk("R2 image off0", cfg[7:0], 8'h5A);

    // R2: second data byte in single mode is refused
    exp_q.push_back({8'd5, 8'h77}); mdl[5] = 8'h77;
    bus_start;
    wr_byte(8'hD2, a); wr_byte(8'h85, a);
    wr_byte(8'h77, a); chk("R2 first data ack", {7'd0, a}, 8'd1);
    wr_byte(8'h88, a); chk("R2 extra data nack", {7'd0, a}, 8'd0);
    bus_stop;
    single_read(5, d); chk("R2 off5 kept", d, 8'h77);
    single_read(6, d); chk("R2 off6 untouched", d, 8'hFF);

    // R1: foreign address ignored until next start
    bus_start;
    wr_byte(8'hA0, a); chk("R1 foreign addr nack", {7'd0, a}, 8'd0);
    wr_byte(8'h80, a); chk("R1 later byte nack", {7'd0, a}, 8'd0);
    wr_byte(8'h99, a); chk("R1 later data nack", {7'd0, a}, 8'd0);
    bus_stop;
    chk("R1 line released", {7'd0, sda_oe}, 8'd0);
    single_read(0, d); chk("R1 off0 unchanged", d, 8'h5A);

    // R4: block write with count 3, fourth byte refused
    exp_q.push_back({8'd0, 8'h11}); mdl[0] = 8'h11;
    exp_q.push_back({8'd1, 8'h22}); mdl[1] = 8'h22;
    exp_q.push_back({8'd2, 8'h33}); mdl[2] = 8'h33;
    bus_start;
    wr_byte(8'hD2, a);
    wr_byte(8'h00, a); chk("R4 block cmd ack", {7'd0, a}, 8'd1);
    wr_byte(8'h03, a); chk("R4 count ack", {7'd0, a}, 8'd1);
    wr_byte(8'h11, a); chk("R4 data0 ack", {7'd0, a}, 8'd1);
    wr_byte(8'h22, a); chk("R4 data1 ack", {7'd0, a}, 8'd1);
    wr_byte(8'h33, a); chk("R4 data2 ack", {7'd0, a}, 8'd1);
    wr_byte(8'h44, a); chk("R4 beyond count nack", {7'd0, a}, 8'd0);
    bus_stop;
    for (int i = 0; i < 4; i++) chk("R4 image", cfg[8*i +: 8], mdl[i]);

    // R7: read-only bits
    single_write(8, 8'h00, "R7");
    single_read(8, d); chk("R7 id byte kept", d, 8'h05);
    single_write(15, 8'h04, "R7");
    single_read(15, d); chk("R7 strap field kept", d, 8'hAC);

    // R8: hardware set, write 0 keeps, write 1 clears
    @(negedge clk); hw_set[74] = 1'b1;
    @(negedge clk); hw_set[74] = 1'b0;
    mdl[9][2] = 1'b1;
    single_read(9, d); chk("R8 set by pulse", d, 8'h04);
    single_write(9, 8'h00, "R8");
    single_read(9, d); chk("R8 zero keeps bit", d, 8'h04);
    single_write(9, 8'h14, "R8");
    single_read(9, d); chk("R8 one clears bit", d, 8'h10);

    // R10: out-of-range write discarded, reads zero
    single_write(20, 8'hEE, "R10");
    single_read(20, d); chk("R10 read beyond file", d, 8'h00);

    // R5 R10: block read through the whole file and one past it
    bus_start;
    wr_byte(8'hD2, a); wr_byte(8'h00, a);
    bus_start;
    wr_byte(8'hD3, a); chk("R5 read addr ack", {7'd0, a}, 8'd1);
    rd_byte(d, 1'b1); chk("R5 count byte", d, 8'd18);
    for (int i = 0; i < NR; i++) begin
      rd_byte(d, 1'b1); chk("R5 block data", d, mdl[i]);
    end
    rd_byte(d, 1'b0); chk("R10 block past end", d, 8'h00);
    bus_stop;

    // R5: short block read ended early by host
    bus_start;
    wr_byte(8'hD2, a); wr_byte(8'h00, a);
    bus_start;
    wr_byte(8'hD3, a);
    rd_byte(d, 1'b1); chk("R5 short count", d, 8'd18);
    rd_byte(d, 1'b0); chk("R5 short data0", d, mdl[0]);
    bus_stop;
    chk("R5 line released after nack", {7'd0, sda_oe}, 8'd0);

    tick(20);
    chk("R9 all strobes seen", 8'(exp_q.size()), 8'd0);
    finish_run();
  end

endmodule